// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the serial slave side of a small byte-wide nonvolatile memory. It oversamples the chip select, serial clock, serial input and hold pins in the system clock domain. It takes input bits on rising serial-clock edges and moves output bits on falling edges, so both clock modes 0 and 3 work. After chip select falls, the first byte is an opcode, and bit 3 of that byte is ignored. Read and write commands then take a 16-bit address, most significant byte first, of which only the low bits that index the array are used.

A read streams bytes from an internal 1024x8 array model. The address increments after every byte and wraps from the top of the array to zero. Write commands do not touch the array. Each received data byte is handed to an external write controller as a one-cycle strobe, together with its address. A commit strobe follows when chip select rises cleanly on a byte boundary. The write-enable commands produce one-cycle strobes. A status byte supplied by the status block is returned for as long as the host keeps clocking. A hold input freezes the bit sequence, and while it is active the output enable is deasserted.

The serial clock high and low phases must each last at least four system clock cycles.

Top module: `sermem_front`

## Requirements
- R1: While chip select is high, so_oe_o is 0 and serial-clock or serial-input activity produces no strobe.
- R2: The opcode is taken most significant bit first, and bit 3 of it is ignored: 0x0E acts exactly like 0x06.
- R3: Opcode 0x06 pulses wen_set_o and 0x04 pulses wen_clr_o, each once per transaction. At most one of wen_set_o, wen_clr_o, wbyte_vld_o and commit_o is high in any cycle.
- R4: Opcode 0x03 followed by a 16-bit address returns the array byte at the address bits [9:0], most significant bit first, with so_oe_o high from the first data bit. Address bits [15:10] are ignored.
- R5: Continued clocking during a read returns successive addresses, and the address wraps from 0x3FF to 0x000.
- R6: Opcode 0x05 returns status_i on every following byte until chip select rises.
- R7: Opcode 0x02 followed by an address presents each data byte on wbyte_vld_o, wbyte_o and waddr_o with wstat_o=0. Only the low 5 address bits advance, wrapping inside the 32-byte page.
- R8: Opcode 0x01 presents its data byte with wstat_o=1. commit_o pulses once when chip select rises on a byte boundary after a status byte, or after at least one array data byte. There is no commit after a rise in mid-byte, or after a write that carried no data.
- R9: An unrecognised opcode gives no strobe and leaves so_oe_o at 0 until chip select falls again. The next transaction then works normally.
- R10: While busy_i is high, every opcode except 0x05 is ignored as in R9, and 0x05 still returns status.
- R11: Hold, asserted or released only while the serial clock is low, keeps so_oe_o at 0, ignores the serial clock and serial input, and keeps the bit position, so the transfer resumes intact.
- R12: Transactions started with the serial clock idle high (mode 3) behave like those started with it idle low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| busy_i | input | 1 | Write cycle in progress |
| status_i | input | 8 | Status byte to return |
| wen_set_o | output | 1 | Set-write-enable strobe |
| wen_clr_o | output | 1 | Clear-write-enable strobe |
| wbyte_vld_o | output | 1 | Received write byte strobe |
| wbyte_o | output | 8 | Received write byte |
| waddr_o | output | 10 | Array address of the write byte |
| wstat_o | output | 1 | Write byte targets the status register |
| commit_o | output | 1 | Start programming strobe |
| arr_we_i | input | 1 | Array write enable from the write controller |
| arr_waddr_i | input | 10 | Array write address |
| arr_wdata_i | input | 8 | Array write data |

## Verification
Several properties are checked on every cycle:
- the output enable stays low while deselected, while held, and in the ignore state;
- the bit counter stays frozen while held;
- the ignore state is left only through deselection;
- an opcode other than read-status that arrives under busy always goes to the ignore state;
- the strobes are mutually exclusive.

Some behaviours can only be shown by the bench's directed transactions. These are:
- the returned data values, including address wrap and ignored upper address bits;
- the page wrap of write addresses;
- when commit fires and when it must not;
- that a transfer interrupted by hold resumes with the right bits in both clock modes.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_AHI, S_ALO, S_RDAT, S_RSTAT, S_WDAT, S_WSTAT, S_WSDONE, S_IGN
  } st_e;

  localparam logic [7:0] OP_MASK  = 8'hF7;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_RARR  = 8'h03;
  localparam logic [7:0] OP_WARR  = 8'h02;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int              N       = 4,
  parameter int              STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sermem_shift.sv
module sermem_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sck_s_i,
  input  logic          si_s_i,
  input  logic          hold_s_i,
  input  logic          rd_phase_i,
  input  logic [BW-1:0] load_i,
  output logic          cs_rise_o,
  output logic          byte_done_o,
  output logic [BW-1:0] rx_byte_o,
  output logic [$clog2(BW)-1:0] bit_cnt_o,
  output logic          load_stb_o,
  output logic          hold_act_o,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic          cs_q, sck_q, hold_act, out_valid, oe_q, done_q;
  logic [CW-1:0] bit_cnt;
  logic [BW-1:0] rx_sh, tx_sh, rx_q;
  logic          rise, fall;

  assign rise       = !cs_s_i && !hold_act && sck_s_i && !sck_q;
  assign fall       = !cs_s_i && !hold_act && !sck_s_i && sck_q;
  assign load_stb_o = fall && rd_phase_i && (bit_cnt == '0);
  assign cs_rise_o  = cs_s_i && !cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      hold_act  <= 1'b0;
      out_valid <= 1'b0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_q      <= '0;
    end else begin
      cs_q   <= cs_s_i;
      sck_q  <= sck_s_i;
      done_q <= rise && (bit_cnt == LAST);
      if (rise && bit_cnt == LAST) rx_q <= {rx_sh[BW-2:0], si_s_i};
      if (cs_s_i) begin
        bit_cnt   <= '0;
        hold_act  <= 1'b0;
        out_valid <= 1'b0;
      end else begin
        // hold changes state only while the serial clock is low
        if (!sck_s_i) hold_act <= !hold_s_i;
        if (rise) begin
          rx_sh   <= {rx_sh[BW-2:0], si_s_i};
          bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
        if (fall) begin
          if (load_stb_o) begin
            tx_sh     <= load_i;
            out_valid <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[BW-2:0], 1'b0};
          end
        end
      end
      oe_q <= !cs_s_i && rd_phase_i && out_valid && !hold_act;
    end
  end

  assign byte_done_o = done_q;
  assign rx_byte_o   = rx_q;
  assign bit_cnt_o   = bit_cnt;
  assign hold_act_o  = hold_act;
  assign so_o        = tx_sh[BW-1];
  assign so_oe_o     = oe_q;
endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
  import sermem_pkg::*;
#(
  parameter int AW = 10,
  parameter int PB = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          cs_rise_i,
  input  logic [2:0]    bit_cnt_i,
  input  logic          byte_done_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          load_stb_i,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          rd_phase_o,
  output logic [7:0]    load_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wen_set_o,
  output logic          wen_clr_o,
  output logic          wbyte_vld_o,
  output logic [7:0]    wbyte_o,
  output logic [AW-1:0] waddr_o,
  output logic          wstat_o,
  output logic          commit_o,
  output st_e           state_o
);
  st_e           state;
  logic          is_rd, got;
  logic [AW-1:0] ptr;
  logic [7:0]    op_m;

  assign op_m = rx_byte_i & OP_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      is_rd       <= 1'b0;
      got         <= 1'b0;
      ptr         <= '0;
      wen_set_o   <= 1'b0;
      wen_clr_o   <= 1'b0;
      wbyte_vld_o <= 1'b0;
      wbyte_o     <= '0;
      waddr_o     <= '0;
      wstat_o     <= 1'b0;
      commit_o    <= 1'b0;
    end else begin
      wen_set_o   <= 1'b0;
      wen_clr_o   <= 1'b0;
      wbyte_vld_o <= 1'b0;
      commit_o    <= 1'b0;
      if (cs_s_i) begin
        state <= S_IDLE;
        got   <= 1'b0;
        // commit only on a clean byte boundary
        if (cs_rise_i && bit_cnt_i == '0 &&
            ((state == S_WDAT && got) || state == S_WSDONE))
          commit_o <= 1'b1;
      end else if (state == S_IDLE) begin
        state <= S_OPC;
      end else begin
        if (byte_done_i) begin
          unique case (state)
            S_OPC: begin
              if (busy_i && op_m != OP_RSTAT) state <= S_IGN;
              else begin
                unique case (op_m)
                  OP_WEN:   begin wen_set_o <= 1'b1; state <= S_IGN; end
                  OP_WDIS:  begin wen_clr_o <= 1'b1; state <= S_IGN; end
                  OP_RSTAT: state <= S_RSTAT;
                  OP_WSTAT: state <= S_WSTAT;
                  OP_RARR:  begin is_rd <= 1'b1; state <= S_AHI; end
                  OP_WARR:  begin is_rd <= 1'b0; state <= S_AHI; end
                  default:  state <= S_IGN;
                endcase
              end
            end
            S_AHI: begin
              ptr[AW-1:8] <= rx_byte_i[AW-9:0];
              state       <= S_ALO;
            end
            S_ALO: begin
              ptr[7:0] <= rx_byte_i;
              state    <= is_rd ? S_RDAT : S_WDAT;
            end
            S_WDAT: begin
              wbyte_vld_o <= 1'b1;
              wbyte_o     <= rx_byte_i;
              waddr_o     <= ptr;
              wstat_o     <= 1'b0;
              got         <= 1'b1;
              ptr         <= {ptr[AW-1:PB], ptr[PB-1:0] + 1'b1};
            end
            S_WSTAT: begin
              wbyte_vld_o <= 1'b1;
              wbyte_o     <= rx_byte_i;
              waddr_o     <= '0;
              wstat_o     <= 1'b1;
              state       <= S_WSDONE;
            end
            default: ;
          endcase
        end
        if (load_stb_i && state == S_RDAT) ptr <= ptr + 1'b1;
      end
    end
  end

  assign rd_phase_o = (state == S_RDAT) || (state == S_RSTAT);
  assign load_o     = (state == S_RSTAT) ? status_i : mem_rdata_i;
  assign rd_addr_o  = ptr;
  assign state_o    = state;
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sermem_front.sv
module sermem_front
  import sermem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PB    = 5,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          si_i,
  input  logic          hold_ni,
  output logic          so_o,
  output logic          so_oe_o,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  output logic          wen_set_o,
  output logic          wen_clr_o,
  output logic          wbyte_vld_o,
  output logic [7:0]    wbyte_o,
  output logic [AW-1:0] waddr_o,
  output logic          wstat_o,
  output logic          commit_o,
  input  logic          arr_we_i,
  input  logic [AW-1:0] arr_waddr_i,
  input  logic [7:0]    arr_wdata_i
);
  logic [3:0]    pins_s;
  logic          cs_s, sck_s, si_s, hold_s;
  logic          cs_rise, byte_done, load_stb, hold_act, rd_phase;
  logic [7:0]    rx_byte, load_byte, mem_rdata;
  logic [2:0]    bit_cnt;
  logic [AW-1:0] rd_addr;
  st_e           state;

  sermem_sync #(.N(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_ni, si_i, sck_i, cs_ni}),
    .q_o   (pins_s)
  );
  assign {hold_s, si_s, sck_s, cs_s} = pins_s;

  sermem_shift #(.BW(8)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .sck_s_i    (sck_s),
    .si_s_i     (si_s),
    .hold_s_i   (hold_s),
    .rd_phase_i (rd_phase),
    .load_i     (load_byte),
    .cs_rise_o  (cs_rise),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .bit_cnt_o  (bit_cnt),
    .load_stb_o (load_stb),
    .hold_act_o (hold_act),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  sermem_ctrl #(.AW(AW), .PB(PB)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .cs_rise_i  (cs_rise),
    .bit_cnt_i  (bit_cnt),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .load_stb_i (load_stb),
    .busy_i     (busy_i),
    .status_i   (status_i),
    .mem_rdata_i(mem_rdata),
    .rd_phase_o (rd_phase),
    .load_o     (load_byte),
    .rd_addr_o  (rd_addr),
    .wen_set_o  (wen_set_o),
    .wen_clr_o  (wen_clr_o),
    .wbyte_vld_o(wbyte_vld_o),
    .wbyte_o    (wbyte_o),
    .waddr_o    (waddr_o),
    .wstat_o    (wstat_o),
    .commit_o   (commit_o),
    .state_o    (state)
  );

  sermem_array #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_array (
    .clk_i  (clk_i),
    .we_i   (arr_we_i),
    .waddr_i(arr_waddr_i),
    .wdata_i(arr_wdata_i),
    .raddr_i(rd_addr),
    .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/sermem_front_chk.sv
module sermem_front_chk
  import sermem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       hold_act,
  input logic [2:0] bit_cnt,
  input st_e        state,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input logic       busy_i,
  input logic       so_oe_o,
  input logic       wen_set_o,
  input logic       wen_clr_o,
  input logic       wbyte_vld_o,
  input logic       commit_o
);
  AST_DESEL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) && cs_s |-> !so_oe_o); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wen_set_o, wen_clr_o, wbyte_vld_o, commit_o})); // R3

  AST_IGN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_IGN |=> (state == S_IGN || state == S_IDLE)); // R9

  AST_IGN_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state == S_IGN) && state == S_IGN |-> !so_oe_o); // R9

  AST_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !cs_s && state == S_OPC && busy_i && ((rx_byte & OP_MASK) != OP_RSTAT)
    |=> state == S_IGN); // R10

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act && $past(hold_act) && !cs_s |-> $stable(bit_cnt)); // R11

  AST_HOLD_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_act) |-> !so_oe_o); // R11
endmodule

bind sermem_front sermem_front_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s       (cs_s),
  .hold_act   (hold_act),
  .bit_cnt    (bit_cnt),
  .state      (state),
  .byte_done  (byte_done),
  .rx_byte    (rx_byte),
  .busy_i     (busy_i),
  .so_oe_o    (so_oe_o),
  .wen_set_o  (wen_set_o),
  .wen_clr_o  (wen_clr_o),
  .wbyte_vld_o(wbyte_vld_o),
  .commit_o   (commit_o)
);

// File: tb/sermem_front_tb_top.sv
module sermem_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic       so, so_oe, busy = 1'b0;
  logic [7:0] status = 8'h00;
  logic       wen_set, wen_clr, wbyte_vld, wstat, commit;
  logic [7:0] wbyte;
  logic [9:0] waddr;
  logic       arr_we = 1'b0;
  logic [9:0] arr_waddr = '0;
  logic [7:0] arr_wdata = '0;

  int n_chk = 0, n_err = 0;
  int n_set = 0, n_clr = 0, n_wb = 0, n_com = 0;
  bit oe_seen = 1'b0;
  bit finished = 1'b0;
  logic [7:0] lg_data [16];
  logic [9:0] lg_addr [16];
  logic       lg_stat [16];
  logic [7:0] rd_buf [8];
  bit         rd_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sermem_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .status_i(status),
    .wen_set_o(wen_set), .wen_clr_o(wen_clr), .wbyte_vld_o(wbyte_vld), .wbyte_o(wbyte),
    .waddr_o(waddr), .wstat_o(wstat), .commit_o(commit),
    .arr_we_i(arr_we), .arr_waddr_i(arr_waddr), .arr_wdata_i(arr_wdata)
  );

  always @(posedge clk) begin
    if (wen_set) n_set++;
    if (wen_clr) n_clr++;
    if (commit) n_com++;
    if (so_oe) oe_seen = 1'b1;
    if (wbyte_vld) begin
      if (n_wb < 16) begin
        lg_data[n_wb] = wbyte;
        lg_addr[n_wb] = waddr;
        lg_stat[n_wb] = wstat;
      end
      n_wb++;
    end
  end

  function automatic logic [7:0] pat(input logic [9:0] a);
    return 8'((a * 37 + 11) & 10'h0FF);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mem_put(input logic [9:0] a, input logic [7:0] d);
    arr_we = 1'b1; arr_waddr = a; arr_wdata = d;
    tick(1);
    arr_we = 1'b0;
  endtask

  task automatic spi_start(input bit m3);
    sck = m3;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic spi_stop(input bit m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1;
    tick(2 * HALF);
    sck = m3;
    tick(HALF);
  endtask

  // shifts nbits of tx MSB first; hold_bit selects a bit index to pause on (-1: none)
  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_bit,
                      output logic [7:0] rx, output bit oe_all);
    rx = '0;
    oe_all = 1'b1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sck = 1'b0; si = tx[i];
      tick(HALF);
      if (i == hold_bit) begin
        hold_n = 1'b0;
        tick(HALF);
        chk(so_oe == 1'b0, "R11 output off during hold", 32'(so_oe), 0);
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; si = ~tx[i]; tick(HALF);
          sck = 1'b0; tick(HALF);
        end
        si = tx[i];
        hold_n = 1'b1;
        tick(HALF);
      end
      rx[i] = so;
      oe_all = oe_all & so_oe;
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; bit o;
    xfer(tx, 8, -1, r, o);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input bit m3,
                         input int hbyte, input int hbit);
    logic [7:0] r; bit o;
    spi_start(m3);
    send(8'h03); send(a[15:8]); send(a[7:0]);
    rd_oe = 1'b1;
    for (int b = 0; b < n; b++) begin
      xfer(8'h00, 8, (b == hbyte) ? hbit : -1, r, o);
      rd_buf[b] = r;
      rd_oe = rd_oe & o;
    end
    spi_stop(m3);
  endtask

  task automatic t_reset;
    int s0, c0, w0, m0;
    chk(so_oe == 1'b0, "R1 reset output enable", 32'(so_oe), 0);
    chk(n_set + n_clr + n_wb + n_com == 0, "R1 reset strobes", 32'(n_set + n_clr + n_wb + n_com), 0);
    s0 = n_set; c0 = n_clr; w0 = n_wb; m0 = n_com; oe_seen = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sck = ~sck; si = i[1]; tick(HALF);
    end
    sck = 1'b0; tick(HALF);
    chk(!oe_seen, "R1 deselected output off", 32'(oe_seen), 0);
    chk(n_set == s0 && n_clr == c0 && n_wb == w0 && n_com == m0, "R1 deselected no strobe",
        32'(n_set + n_clr + n_wb + n_com), 32'(s0 + c0 + w0 + m0));
  endtask

  task automatic t_wren;
    int s0, c0;
    s0 = n_set; c0 = n_clr;
    spi_start(0); send(8'h06); spi_stop(0);
    chk(n_set == s0 + 1, "R3 set write enable", 32'(n_set), 32'(s0 + 1));
    spi_start(0); send(8'h0E); spi_stop(0);
    chk(n_set == s0 + 2, "R2 bit 3 ignored", 32'(n_set), 32'(s0 + 2));
    spi_start(0); send(8'h04); send(8'h04); spi_stop(0);
    chk(n_clr == c0 + 1, "R3 clear write enable once", 32'(n_clr), 32'(c0 + 1));
  endtask

  task automatic t_read;
    do_read(16'hFC05, 3, 0, -1, -1);
    chk(rd_buf[0] == pat(10'h005), "R4 read upper address ignored", 32'(rd_buf[0]), 32'(pat(10'h005)));
    chk(rd_oe, "R4 output enabled during data", 32'(rd_oe), 1);
    chk(rd_buf[1] == pat(10'h006) && rd_buf[2] == pat(10'h007), "R5 auto increment",
        32'({rd_buf[1], rd_buf[2]}), 32'({pat(10'h006), pat(10'h007)}));
    do_read(16'h03FE, 3, 0, -1, -1);
    chk(rd_buf[0] == pat(10'h3FE) && rd_buf[1] == pat(10'h3FF), "R5 top of array",
        32'({rd_buf[0], rd_buf[1]}), 32'({pat(10'h3FE), pat(10'h3FF)}));
    chk(rd_buf[2] == pat(10'h000), "R5 wrap to zero", 32'(rd_buf[2]), 32'(pat(10'h000)));
  endtask

  task automatic t_rdstat(input bit m3);
    logic [7:0] r; bit o; bit ok;
    status = m3 ? 8'h3C : 8'hA5;
    ok = 1'b1;
    spi_start(m3); send(8'h05);
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00, 8, -1, r, o);
      ok = ok & (r == status) & o;
    end
    spi_stop(m3);
    chk(ok, m3 ? "R12 status read mode 3" : "R6 status repeated", 32'(r), 32'(status));
  endtask

  task automatic t_write;
    int w0, m0;
    logic [7:0] r; bit o;
    w0 = n_wb; m0 = n_com;
    spi_start(0); send(8'h02); send(8'h00); send(8'h3E);
    send(8'h11); send(8'h22); send(8'h33);
    spi_stop(0);
    chk(n_wb == w0 + 3 && lg_data[w0] == 8'h11 && lg_data[w0+2] == 8'h33 && !lg_stat[w0],
        "R7 write bytes", 32'(n_wb - w0), 3);
    chk(lg_addr[w0] == 10'h03E && lg_addr[w0+1] == 10'h03F && lg_addr[w0+2] == 10'h020,
        "R7 page wrap", 32'({lg_addr[w0+1], lg_addr[w0+2]}), 32'({10'h03F, 10'h020}));
    chk(n_com == m0 + 1, "R8 commit after data", 32'(n_com), 32'(m0 + 1));
    // aborted mid byte
    spi_start(0); send(8'h02); send(8'h00); send(8'h10); send(8'hAA);
    xfer(8'h55, 4, -1, r, o);
    spi_stop(0);
    chk(n_com == m0 + 1, "R8 no commit mid byte", 32'(n_com), 32'(m0 + 1));
    // no data byte
    spi_start(0); send(8'h02); send(8'h00); send(8'h10); spi_stop(0);
    chk(n_com == m0 + 1, "R8 no commit without data", 32'(n_com), 32'(m0 + 1));
    w0 = n_wb;
    spi_start(0); send(8'h01); send(8'h8C); spi_stop(0);
    chk(n_wb == w0 + 1 && lg_stat[w0] && lg_data[w0] == 8'h8C, "R8 status byte",
        32'(lg_data[w0]), 32'h8C);
    chk(n_com == m0 + 2, "R8 commit after status", 32'(n_com), 32'(m0 + 2));
  endtask

  task automatic t_invalid;
    int s0, c0, w0, m0;
    s0 = n_set; c0 = n_clr; w0 = n_wb; m0 = n_com;
    oe_seen = 1'b0;
    spi_start(0); send(8'h07); send(8'h03); send(8'h06); send(8'h00); spi_stop(0);
    chk(!oe_seen, "R9 output stays off", 32'(oe_seen), 0);
    chk(n_set == s0 && n_clr == c0 && n_wb == w0 && n_com == m0, "R9 no strobes",
        32'(n_set + n_clr + n_wb + n_com), 32'(s0 + c0 + w0 + m0));
    do_read(16'h0007, 1, 0, -1, -1);
    chk(rd_buf[0] == pat(10'h007), "R9 recovery on next select", 32'(rd_buf[0]), 32'(pat(10'h007)));
  endtask

  task automatic t_busy;
    int s0;
    logic [7:0] r; bit o;
    s0 = n_set;
    busy = 1'b1;
    spi_start(0); send(8'h06); spi_stop(0);
    chk(n_set == s0, "R10 enable ignored while busy", 32'(n_set), 32'(s0));
    oe_seen = 1'b0;
    do_read(16'h0005, 1, 0, -1, -1);
    chk(!oe_seen, "R10 read ignored while busy", 32'(oe_seen), 0);
    status = 8'hFF;
    spi_start(0); send(8'h05); xfer(8'h00, 8, -1, r, o); spi_stop(0);
    chk(r == 8'hFF && o, "R10 status while busy", 32'(r), 32'hFF);
    busy = 1'b0;
  endtask

  task automatic t_hold;
    int w0;
    logic [7:0] r; bit o;
    do_read(16'h0005, 2, 0, 0, 3);
    chk(rd_buf[0] == pat(10'h005) && rd_buf[1] == pat(10'h006), "R11 read resumes",
        32'({rd_buf[0], rd_buf[1]}), 32'({pat(10'h005), pat(10'h006)}));
    w0 = n_wb;
    spi_start(0); send(8'h02); send(8'h00); send(8'h01);
    xfer(8'h5A, 8, 5, r, o);
    spi_stop(0);
    chk(n_wb == w0 + 1 && lg_data[w0] == 8'h5A && lg_addr[w0] == 10'h001,
        "R11 input ignored in hold", 32'(lg_data[w0]), 32'h5A);
  endtask

  task automatic t_mode3;
    do_read(16'h0006, 2, 1, -1, -1);
    chk(rd_buf[0] == pat(10'h006) && rd_buf[1] == pat(10'h007) && rd_oe, "R12 read mode 3",
        32'({rd_buf[0], rd_buf[1]}), 32'({pat(10'h006), pat(10'h007)}));
    t_rdstat(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    foreach (lg_stat[i]) begin lg_stat[i] = 1'b0; lg_data[i] = '0; lg_addr[i] = '0; end
    mem_put(10'h000, pat(10'h000));
    for (int a = 5; a < 8; a++) mem_put(10'(a), pat(10'(a)));
    mem_put(10'h3FE, pat(10'h3FE));
    mem_put(10'h3FF, pat(10'h3FF));
    t_reset();
    t_wren();
    t_read();
    t_rdstat(0);
    t_write();
    t_invalid();
    t_busy();
    t_hold();
    t_mode3();
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule